// File: doc/BRIEF.md
# Vector Floating-Point Scalar Move Unit

This unit recognises and carries out the two vector floating-point scalar moves. One reads element 0 of a vector register and writes it to a 64-bit floating-point register. When the element is narrower than 64 bits, every bit above the element is set to 1, so that a narrow value is NaN-boxed. The other reads a floating-point register and stores it into element 0 of a vector register. In the same write, every other byte of that vector register is cleared. The register group setting is ignored, so only one register is written. When the active vector length is zero, the vector register is not written at all.

The unit sits beside the other vector execution units and watches the issued instruction word. It drives the read addresses of both register files from the instruction fields, and the register files return the read data in the same cycle. The result is registered and appears on the write ports one cycle after the valid strobe. A legal move that reads a vector register also raises the floating-point dirty strobe. A matched move that fails a legality check raises illegal-instruction and writes nothing. An instruction word that matches neither move leaves the unit idle, because another unit handles it.

Top module: `vfsmov_unit`

## Requirements
- R1: A word with opcode bits[6:0]=1010111, bit 25=1, bits[31:26]=001100, bits[19:15]=00000 and bits[14:12]=001 is the vector-to-FP move: source vector register bits[24:20], destination FP register bits[11:7].
- R2: A word with opcode bits[6:0]=1010111, bit 25=1, bits[31:26]=001101, bits[24:20]=00000 and bits[14:12]=101 is the FP-to-vector move: source FP register bits[19:15], destination vector register bits[11:7].
- R3: Either move is illegal when vill is 1, when the F extension flag is 0, or when the SEW code is 0 (8-bit elements). SEW codes 1, 2 and 3 select 16, 32 and 64-bit elements.
- R4: The vector-to-FP move is also illegal when the FS field is 0. The FP-to-vector move does not depend on FS.
- R5: An illegal matched move raises illegal_instr for one cycle and leaves vrf_we, fpr_we and fs_dirty low.
- R6: The vector-to-FP move writes the low SEW bits of vector bit range [63:0] of the source. All FP result bits from the element width up to bit 63 are 1.
- R7: fs_dirty pulses in exactly the cycles in which a vector-to-FP move writes the FP register.
- R8: An FP-to-vector move with vl equal to 0 is legal but does not write the vector register: vrf_we stays low and illegal_instr stays low.
- R9: An FP-to-vector move with a nonzero vl writes all VLEN bits of the destination. Bits [SEW-1:0] hold the low SEW bits of the FP value and all other bits are 0.
- R10: For SEW code 3 with the D extension flag at 0, bits [63:32] of the stored element are all 1. In every other case the FP value is stored unchanged.
- R11: An instruction word that matches neither move, or any word presented with instr_valid low, produces no write, no illegal_instr and no fs_dirty.
- R12: All outputs are registered. Each accepted instruction affects the outputs for exactly the one cycle after the clock edge that samples it, and after reset every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Issued instruction word |
| sew_code | input | 2 | Element width code: width is 8 shifted left by this value |
| vl | input | VL_W | Active vector length |
| vill | input | 1 | Vector configuration is illegal |
| fs_state | input | 2 | FP unit status field, 0 means off |
| has_f | input | 1 | Single-precision FP extension is present |
| has_d | input | 1 | Double-precision FP extension is present |
| vrf_raddr | output | 5 | Vector register file read address |
| vrf_rdata | input | VLEN | Vector register file read data, same cycle |
| fpr_raddr | output | 5 | FP register file read address |
| fpr_rdata | input | 64 | FP register file read data, same cycle |
| vrf_we | output | 1 | Vector register write enable |
| vrf_waddr | output | 5 | Vector register write address |
| vrf_wdata | output | VLEN | Vector register write data, whole register |
| fpr_we | output | 1 | FP register write enable |
| fpr_waddr | output | 5 | FP register write address |
| fpr_wdata | output | 64 | FP register write data |
| illegal_instr | output | 1 | Matched move failed a legality check |
| fs_dirty | output | 1 | FP state became dirty |

## Verification
Every output of this unit is a register that is loaded from the decode result on the edge that samples the instruction. A wrong decode or legality decision therefore shows up at the strobes in the very next cycle. It appears as a missing write, a spurious write, or an illegal_instr pulse on a word that another unit owns. A wrong width mask or boxing choice shows up in the same cycle as wrong upper bits of fpr_wdata or vrf_wdata. To expose these, the bench uses register contents whose upper bits are neither all 0 nor all 1. A stale or held strobe shows up one cycle later, as a write in a cycle in which the reference model expects the unit to be idle.

// File: rtl/vfsmov_pkg.sv
package vfsmov_pkg;

  localparam int unsigned RIDX_W = 5;
  localparam int unsigned FP_W   = 64;

  localparam logic [6:0] OPC_VECTOR = 7'b1010111;
  localparam logic [5:0] F6_TO_FP   = 6'b001100;
  localparam logic [5:0] F6_TO_VEC  = 6'b001101;
  localparam logic [2:0] F3_TO_FP   = 3'b001;
  localparam logic [2:0] F3_TO_VEC  = 3'b101;

  typedef enum logic [1:0] {
    MV_NONE   = 2'd0,
    MV_TO_FP  = 2'd1,
    MV_TO_VEC = 2'd2
  } mv_kind_e;

  // Bits covered by one element of the selected width.
  function automatic logic [FP_W-1:0] width_mask(input logic [1:0] sew);
    logic [FP_W-1:0] m;
    case (sew)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return m;
  endfunction

  // Keep the element bits and set every bit above them to 1.
  function automatic logic [FP_W-1:0] box_element(input logic [FP_W-1:0] raw,
                                                  input logic [1:0]      sew);
    return raw | ~width_mask(sew);
  endfunction

  // FP source value as stored into a vector element.
  function automatic logic [FP_W-1:0] fp_store_value(input logic [FP_W-1:0] raw,
                                                     input logic [1:0]      sew,
                                                     input logic            d_present);
    if (sew == 2'd3 && !d_present)
      return {32'hFFFF_FFFF, raw[31:0]};
    return raw;
  endfunction

endpackage

// File: rtl/vfsmov_decode.sv
module vfsmov_decode
  import vfsmov_pkg::*;
(
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic [1:0]        sew_code,
  input  logic              vill,
  input  logic [1:0]        fs_state,
  input  logic              has_f,
  output mv_kind_e          kind,
  output logic [RIDX_W-1:0] src_vec_idx,
  output logic [RIDX_W-1:0] src_fp_idx,
  output logic [RIDX_W-1:0] dst_idx,
  output logic              hit,
  output logic              fire_to_fp,
  output logic              fire_to_vec,
  output logic              trap
);

  logic [5:0] f6;
  logic [2:0] f3;
  logic       mask_off;
  logic       op_ok;
  logic       is_to_fp;
  logic       is_to_vec;
  logic       cfg_ok;
  logic       fs_on;

  assign f6       = instr_word[31:26];
  assign mask_off = instr_word[25];
  assign f3       = instr_word[14:12];
  assign op_ok    = (instr_word[6:0] == OPC_VECTOR) && mask_off;

  assign src_vec_idx = instr_word[24:20];
  assign src_fp_idx  = instr_word[19:15];
  assign dst_idx     = instr_word[11:7];

  assign is_to_fp  = op_ok && (f6 == F6_TO_FP)  && (f3 == F3_TO_FP)
                     && (src_fp_idx == '0);
  assign is_to_vec = op_ok && (f6 == F6_TO_VEC) && (f3 == F3_TO_VEC)
                     && (src_vec_idx == '0);

  always_comb begin
    kind = MV_NONE;
    if (is_to_fp)       kind = MV_TO_FP;
    else if (is_to_vec) kind = MV_TO_VEC;
  end

  assign cfg_ok = !vill && has_f && (sew_code != 2'd0);
  assign fs_on  = (fs_state != 2'd0);

  assign hit         = instr_valid && (kind != MV_NONE);
  assign fire_to_fp  = hit && (kind == MV_TO_FP)  && cfg_ok && fs_on;
  assign fire_to_vec = hit && (kind == MV_TO_VEC) && cfg_ok;
  assign trap        = hit && !fire_to_fp && !fire_to_vec;

endmodule

// File: rtl/vfsmov_to_fp.sv
module vfsmov_to_fp
  import vfsmov_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic [VLEN-1:0] vreg,
  input  logic [1:0]      sew_code,
  output logic [FP_W-1:0] fp_result
);

  generate
    if (VLEN < FP_W) begin : g_bad_vlen
      $error("vfsmov_to_fp: VLEN must be at least 64");
    end
  endgenerate

  logic [FP_W-1:0] lane0;
  assign lane0     = vreg[FP_W-1:0];
  assign fp_result = box_element(lane0, sew_code);

endmodule

// File: rtl/vfsmov_to_vec.sv
module vfsmov_to_vec
  import vfsmov_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic [FP_W-1:0] fp_value,
  input  logic [1:0]      sew_code,
  input  logic            has_d,
  output logic [VLEN-1:0] vreg_result
);

  localparam int unsigned PAD_W = (VLEN > FP_W) ? VLEN - FP_W : 1;

  logic [FP_W-1:0] stored;
  logic [FP_W-1:0] lane0;

  assign stored = fp_store_value(fp_value, sew_code, has_d);
  assign lane0  = stored & width_mask(sew_code);

  generate
    if (VLEN > FP_W) begin : g_pad
      logic [PAD_W-1:0] upper_zero;
      assign upper_zero  = '0;
      assign vreg_result = {upper_zero, lane0};
    end else begin : g_exact
      assign vreg_result = lane0[VLEN-1:0];
    end
  endgenerate

endmodule

// File: rtl/vfsmov_unit.sv
module vfsmov_unit
  import vfsmov_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic [1:0]        sew_code,
  input  logic [VL_W-1:0]   vl,
  input  logic              vill,
  input  logic [1:0]        fs_state,
  input  logic              has_f,
  input  logic              has_d,
  output logic [4:0]        vrf_raddr,
  input  logic [VLEN-1:0]   vrf_rdata,
  output logic [4:0]        fpr_raddr,
  input  logic [63:0]       fpr_rdata,
  output logic              vrf_we,
  output logic [4:0]        vrf_waddr,
  output logic [VLEN-1:0]   vrf_wdata,
  output logic              fpr_we,
  output logic [4:0]        fpr_waddr,
  output logic [63:0]       fpr_wdata,
  output logic              illegal_instr,
  output logic              fs_dirty
);

  mv_kind_e          dec_kind;
  logic [RIDX_W-1:0] dec_src_vec;
  logic [RIDX_W-1:0] dec_src_fp;
  logic [RIDX_W-1:0] dec_dst;
  logic              dec_hit;
  logic              dec_fire_fp;
  logic              dec_fire_vec;
  logic              dec_trap;
  logic              vec_commit;
  logic [FP_W-1:0]   fp_next;
  logic [VLEN-1:0]   vec_next;

  vfsmov_decode u_decode (
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .sew_code    (sew_code),
    .vill        (vill),
    .fs_state    (fs_state),
    .has_f       (has_f),
    .kind        (dec_kind),
    .src_vec_idx (dec_src_vec),
    .src_fp_idx  (dec_src_fp),
    .dst_idx     (dec_dst),
    .hit         (dec_hit),
    .fire_to_fp  (dec_fire_fp),
    .fire_to_vec (dec_fire_vec),
    .trap        (dec_trap)
  );

  assign vrf_raddr = dec_src_vec;
  assign fpr_raddr = dec_src_fp;

  vfsmov_to_fp #(.VLEN(VLEN)) u_to_fp (
    .vreg      (vrf_rdata),
    .sew_code  (sew_code),
    .fp_result (fp_next)
  );

  vfsmov_to_vec #(.VLEN(VLEN)) u_to_vec (
    .fp_value    (fpr_rdata),
    .sew_code    (sew_code),
    .has_d       (has_d),
    .vreg_result (vec_next)
  );

  // A legal move with an empty vector length commits nothing.
  assign vec_commit = dec_fire_vec && (vl != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vrf_we        <= 1'b0;
      fpr_we        <= 1'b0;
      illegal_instr <= 1'b0;
      fs_dirty      <= 1'b0;
      vrf_waddr     <= '0;
      fpr_waddr     <= '0;
      vrf_wdata     <= '0;
      fpr_wdata     <= '0;
    end else begin
      vrf_we        <= vec_commit;
      fpr_we        <= dec_fire_fp;
      illegal_instr <= dec_trap;
      fs_dirty      <= dec_fire_fp;
      if (vec_commit) begin
        vrf_waddr <= dec_dst;
        vrf_wdata <= vec_next;
      end
      if (dec_fire_fp) begin
        fpr_waddr <= dec_dst;
        fpr_wdata <= fp_next;
      end
    end
  end

endmodule

// File: rtl/vfsmov_checker.sv
module vfsmov_checker #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [1:0]      sew_code,
  input logic [VL_W-1:0] vl,
  input logic            vill,
  input logic [1:0]      fs_state,
  input logic            has_f,
  input logic            has_d,
  input logic            dec_hit,
  input logic            vrf_we,
  input logic [VLEN-1:0] vrf_wdata,
  input logic            fpr_we,
  input logic [63:0]     fpr_wdata,
  input logic            illegal_instr,
  input logic            fs_dirty
);

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_instr |-> (!vrf_we && !fpr_we && !fs_dirty)); // R5

  AST_CFG_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dec_hit) && ($past(vill) || !$past(has_f) || $past(sew_code) == 2'd0))
    |-> illegal_instr); // R3

  AST_FS_OFF_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fpr_we |-> ($past(fs_state) != 2'd0)); // R4

  AST_BOX_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (fpr_we && $past(sew_code) == 2'd1) |-> (&fpr_wdata[63:16])); // R6

  AST_BOX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fpr_we && $past(sew_code) == 2'd2) |-> (&fpr_wdata[63:32])); // R6

  AST_DIRTY_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_dirty |-> fpr_we); // R7

  AST_WRITE_WITH_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    fpr_we |-> fs_dirty); // R7

  AST_EMPTY_VL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we |-> ($past(vl) != '0)); // R8

  AST_VEC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vrf_we && $past(sew_code) == 2'd1) |-> (vrf_wdata[VLEN-1:16] == '0)); // R9

  AST_NO_D_BOX: assert property (@(posedge clk) disable iff (!rst_n)
    (vrf_we && $past(sew_code) == 2'd3 && !$past(has_d)) |-> (&vrf_wdata[63:32])); // R10

  AST_UNOWNED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dec_hit) |-> (!vrf_we && !fpr_we && !illegal_instr && !fs_dirty)); // R11

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vrf_we, fpr_we, illegal_instr})); // R12

  AST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (vrf_we || fpr_we || illegal_instr) |-> $past(instr_valid)); // R12

endmodule

bind vfsmov_unit vfsmov_checker #(.VLEN(VLEN), .VL_W(VL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .sew_code      (sew_code),
  .vl            (vl),
  .vill          (vill),
  .fs_state      (fs_state),
  .has_f         (has_f),
  .has_d         (has_d),
  .dec_hit       (dec_hit),
  .vrf_we        (vrf_we),
  .vrf_wdata     (vrf_wdata),
  .fpr_we        (fpr_we),
  .fpr_wdata     (fpr_wdata),
  .illegal_instr (illegal_instr),
  .fs_dirty      (fs_dirty)
);

// File: tb/vfsmov_unit_bench.sv
module vfsmov_unit_bench;

  localparam int VLEN = 128;
  localparam int VL_W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [31:0]     instr_word = '0;
  logic [1:0]      sew_code = '0;
  logic [VL_W-1:0] vl = '0;
  logic            vill = 1'b0;
  logic [1:0]      fs_state = '0;
  logic            has_f = 1'b0;
  logic            has_d = 1'b0;
  logic [4:0]      vrf_raddr, fpr_raddr, vrf_waddr, fpr_waddr;
  logic [VLEN-1:0] vrf_rdata, vrf_wdata;
  logic [63:0]     fpr_rdata, fpr_wdata;
  logic            vrf_we, fpr_we, illegal_instr, fs_dirty;

  logic [VLEN-1:0] vmem [32];
  logic [63:0]     fmem [32];

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // expected outputs for the next sample point
  logic            e_vwe, e_fwe, e_ill, e_dirty;
  logic [4:0]      e_vaddr, e_faddr;
  logic [VLEN-1:0] e_vdata;
  logic [63:0]     e_fdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign vrf_rdata = vmem[vrf_raddr];
  assign fpr_rdata = fmem[fpr_raddr];

  vfsmov_unit #(.VLEN(VLEN), .VL_W(VL_W)) u_vfsmov_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .sew_code(sew_code), .vl(vl), .vill(vill), .fs_state(fs_state),
    .has_f(has_f), .has_d(has_d), .vrf_raddr(vrf_raddr), .vrf_rdata(vrf_rdata),
    .fpr_raddr(fpr_raddr), .fpr_rdata(fpr_rdata), .vrf_we(vrf_we),
    .vrf_waddr(vrf_waddr), .vrf_wdata(vrf_wdata), .fpr_we(fpr_we),
    .fpr_waddr(fpr_waddr), .fpr_wdata(fpr_wdata), .illegal_instr(illegal_instr),
    .fs_dirty(fs_dirty)
  );

  function automatic logic [31:0] enc_to_fp(input int vs, input int rd);
    return {6'b001100, 1'b1, 5'(vs), 5'd0, 3'b001, 5'(rd), 7'b1010111};
  endfunction

  function automatic logic [31:0] enc_to_vec(input int fs, input int vd);
    return {6'b001101, 1'b1, 5'd0, 5'(fs), 3'b101, 5'(vd), 7'b1010111};
  endfunction

  // Behavioural reference: decide the outcome bit by bit from the requirements.
  task automatic predict(input logic v, input logic [31:0] w, input logic [1:0] s,
                         input logic [VL_W-1:0] len, input logic vi, input logic [1:0] fsf,
                         input logic f, input logic d);
    int width;
    bit common, to_fp, to_vec;
    logic [63:0] val;
    width  = 8 * (1 << s);
    to_fp  = (w[6:0] == 7'b1010111) && w[25] && (w[31:26] == 6'b001100)
             && (w[19:15] == 5'd0) && (w[14:12] == 3'b001);
    to_vec = (w[6:0] == 7'b1010111) && w[25] && (w[31:26] == 6'b001101)
             && (w[24:20] == 5'd0) && (w[14:12] == 3'b101);
    common = !vi && f && (s != 0);
    e_vwe = 0; e_fwe = 0; e_ill = 0; e_dirty = 0;
    if (v && to_fp) begin
      if (common && fsf != 0) begin
        e_fwe = 1; e_dirty = 1; e_faddr = w[11:7];
        for (int b = 0; b < 64; b++)
          e_fdata[b] = (b < width) ? vmem[w[24:20]][b] : 1'b1;
      end else e_ill = 1;
    end else if (v && to_vec) begin
      if (common) begin
        if (len != 0) begin
          val = fmem[w[19:15]];
          if (s == 3 && !d) val[63:32] = '1;
          e_vwe = 1; e_vaddr = w[11:7];
          for (int b = 0; b < VLEN; b++)
            e_vdata[b] = (b < width) ? val[b] : 1'b0;
        end
      end else e_ill = 1;
    end
  endtask

  task automatic check_outputs(input string tag);
    total++;
    if ({vrf_we, fpr_we, illegal_instr, fs_dirty} !== {e_vwe, e_fwe, e_ill, e_dirty}) begin
      bad++;
      $display("FAIL %s: strobes vwe/fwe/ill/dirty=%b%b%b%b expected %b%b%b%b", tag,
               vrf_we, fpr_we, illegal_instr, fs_dirty, e_vwe, e_fwe, e_ill, e_dirty);
    end
    if (e_fwe) begin
      total++;
      if (fpr_waddr !== e_faddr || fpr_wdata !== e_fdata) begin
        bad++;
        $display("FAIL %s: fp write %0d/%h expected %0d/%h", tag,
                 fpr_waddr, fpr_wdata, e_faddr, e_fdata);
      end
    end
    if (e_vwe) begin
      total++;
      if (vrf_waddr !== e_vaddr || vrf_wdata !== e_vdata) begin
        bad++;
        $display("FAIL %s: vec write %0d/%h expected %0d/%h", tag,
                 vrf_waddr, vrf_wdata, e_vaddr, e_vdata);
      end
    end
  endtask

  // Drive just after a falling edge, sample at the next falling edge.
  task automatic issue(input logic v, input logic [31:0] w, input logic [1:0] s,
                       input logic [VL_W-1:0] len, input logic vi, input logic [1:0] fsf,
                       input logic f, input logic d, input string tag);
    instr_valid = v; instr_word = w; sew_code = s; vl = len;
    vill = vi; fs_state = fsf; has_f = f; has_d = d;
    predict(v, w, s, len, vi, fsf, f, d);
    @(posedge clk);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic idle(input string tag);
    issue(1'b0, 32'h0, 2'd2, 16'd4, 1'b0, 2'd1, 1'b1, 1'b1, tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      for (int k = 0; k < VLEN / 8; k++)
        vmem[i][k*8 +: 8] = 8'((i * 37 + k * 11 + 3) & 255);
      fmem[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0000_2222_3333);
    end
    e_vwe = 0; e_fwe = 0; e_ill = 0; e_dirty = 0;
    e_vaddr = '0; e_faddr = '0; e_vdata = '0; e_fdata = '0;
    repeat (3) @(negedge clk);
    check_outputs("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R12 after reset");

    // vector to FP, each legal width
    issue(1, enc_to_fp(3, 7),   2'd1, 16'd5, 0, 2'd1, 1, 1, "R1 R6 R7 sew16");
    issue(1, enc_to_fp(9, 30),  2'd2, 16'd5, 0, 2'd3, 1, 0, "R1 R6 R7 sew32");
    issue(1, enc_to_fp(31, 0),  2'd3, 16'd0, 0, 2'd2, 1, 1, "R1 R6 sew64");
    idle("R12 pulse ends");
    // FP to vector, each legal width
    issue(1, enc_to_vec(4, 12), 2'd1, 16'd1, 0, 2'd0, 1, 1, "R2 R9 R4 sew16 fs off");
    issue(1, enc_to_vec(17, 2), 2'd2, 16'd8, 0, 2'd1, 1, 0, "R2 R9 sew32");
    issue(1, enc_to_vec(21, 5), 2'd3, 16'd2, 0, 2'd1, 1, 1, "R10 sew64 with D");
    issue(1, enc_to_vec(22, 6), 2'd3, 16'd2, 0, 2'd1, 1, 0, "R10 sew64 no D");
    issue(1, enc_to_vec(8, 9),  2'd2, 16'd0, 0, 2'd1, 1, 1, "R8 vl zero");
    // legality
    issue(1, enc_to_fp(2, 3),   2'd2, 16'd4, 1, 2'd1, 1, 1, "R3 R5 vill to fp");
    issue(1, enc_to_vec(2, 3),  2'd2, 16'd4, 1, 2'd1, 1, 1, "R3 R5 vill to vec");
    issue(1, enc_to_fp(2, 3),   2'd2, 16'd4, 0, 2'd1, 0, 1, "R3 no F to fp");
    issue(1, enc_to_vec(2, 3),  2'd1, 16'd4, 0, 2'd1, 0, 1, "R3 no F to vec");
    issue(1, enc_to_fp(2, 3),   2'd0, 16'd4, 0, 2'd1, 1, 1, "R3 sew8 to fp");
    issue(1, enc_to_vec(2, 3),  2'd0, 16'd4, 0, 2'd1, 1, 1, "R3 sew8 to vec");
    issue(1, enc_to_fp(2, 3),   2'd2, 16'd4, 0, 2'd0, 1, 1, "R4 R5 fs off to fp");
    // words owned elsewhere
    issue(1, enc_to_fp(5, 5) & ~32'h0200_0000,  2'd2, 16'd4, 0, 2'd1, 1, 1, "R11 masked form");
    issue(1, enc_to_fp(5, 5) | 32'h0000_8000,   2'd2, 16'd4, 0, 2'd1, 1, 1, "R11 rs1 field nonzero");
    issue(1, enc_to_vec(5, 5) | 32'h0010_0000,  2'd2, 16'd4, 0, 2'd1, 1, 1, "R11 rs2 field nonzero");
    issue(1, (enc_to_vec(5, 5) & ~32'h0000_7000) | 32'h0000_6000, 2'd2, 16'd4, 0, 2'd1, 1, 1, "R11 other funct3");
    issue(1, enc_to_fp(5, 5) ^ 32'h0000_0040,   2'd2, 16'd4, 0, 2'd1, 1, 1, "R11 other opcode");
    issue(1, enc_to_fp(5, 5) & ~32'h0000_7000, 2'd2, 16'd4, 1, 2'd1, 1, 1, "R11 unowned with vill");
    issue(0, enc_to_fp(6, 6),   2'd2, 16'd4, 0, 2'd1, 1, 1, "R11 valid low");
    // back-to-back alternation
    for (int n = 0; n < 16; n++) begin
      if (n % 2 == 0)
        issue(1, enc_to_fp(n, 31 - n), 2'(1 + n % 3), 16'(n), 0, 2'(1 + n % 3), 1, n[1], "R12 burst to fp");
      else
        issue(1, enc_to_vec(n, n + 1), 2'(1 + n % 3), 16'(n % 4), 0, 2'd0, 1, n[2], "R12 burst to vec");
    end
    idle("R12 final idle");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule